// File: doc/BRIEF.md
# Root Hub Downstream Port Controller

This block holds the status of the downstream ports of a USB host controller's root hub, plus one hub-wide status word. Host software drives each port through write-one command bits that enable, disable, suspend, resume, power up or power down the port. It acknowledges events by writing ones to the change bits. Writing zeros does nothing, so software can address one function without a read-modify-write.

A port reset is a timed sequence. The reset command raises the port's reset bit and starts a per-port countdown. A 1 ms frame tick advances the countdown. When it expires, the port leaves reset already enabled, and its reset-change bit is set. Each port's connect state comes from an input. Any change in a stored port value produces a one-cycle request to the controller's interrupt logic. Reads are combinational and have no side effects.

Top module: `rhp_root_hub`

## Requirements
- R1: Word address 0 selects the hub status register. Addresses 1 to 4 select ports 1 to 4. A read of any other address returns 0, and a write to any other address changes no register.
- R2: After reset, the hub register reads 0 and ports 2 to 4 read 0. Port 1 reads 0x00000001, meaning connect status in bit 0. The change request is low.
- R3: In a port write, bit 1 sets the enable status (read bit 1) and bit 0 clears it. When both bits are 1, the enable status is unchanged.
- R4: In a port write, bit 2 sets the suspend status (read bit 2) and bit 3 clears it. When both bits are 1, the suspend status is unchanged.
- R5: In a port write, bit 8 sets the power status (read bit 8) and bit 9 clears it. When both bits are 1, the power status is unchanged.
- R6: A port write with bit 4 set sets the reset status (read bit 4) and loads that port's countdown with 10 frame ticks. Writing it again while the countdown runs reloads it to 10.
- R7: On the 10th frame tick after the last reset command, the port clears bit 4 and sets bit 1 and bit 20 (reset change) in the same cycle. If a host write in that same cycle clears enable or clears bit 20, the completion wins.
- R8: In a port write, bits 16 to 20 clear the connect-change, enable-change, suspend-change, over-current-change and reset-change bits, which read back at the same positions. Zero bits in any write have no effect.
- R9: Port connect status (bit 0) takes the value of that port's connect input one cycle later. Each change sets the connect-change bit 16. This set wins over a same-cycle clear by the host.
- R10: The change request is high for exactly one cycle, in the cycle after any port register value changes. The cause can be a write, a reset completion or a connect change. A port write that leaves the value unchanged raises no request.
- R11: In the hub register, write bit 31 clears bit 15, write bit 17 clears bit 1, and write bit 16 clears bit 0. Event inputs 2, 1 and 0 set bits 15, 1 and 0. A set wins over a same-cycle clear.
- R12: Reading a register does not change it and raises no change request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe every 1 ms frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data (command and clear bits) |
| rd_addr | input | 3 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| conn_in | input | 4 | Connect state per port, bit 0 = port 1 |
| hub_set | input | 3 | Hub event strobes for hub bits 0, 1 and 15 |
| rhsc_req | output | 1 | One-cycle root hub status change request |

## Verification
The sharpest coincidence is a reset countdown expiring on the same edge as a host write to that port. The bench runs a reset for nine ticks. It then raises the tenth frame tick in the same cycle as a write that clears enable and clears the reset-change bit. The port must read back enabled, out of reset and with reset change set. The bench judges connect-input changes against a simultaneous change-bit clear, and hub events against a simultaneous hub clear, the same way.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

    localparam int REG_W = 32;

    // stored fields of one downstream port
    typedef struct packed {
        logic ccs;   // connected
        logic pes;   // enabled
        logic pss;   // suspended
        logic prs;   // in reset
        logic pps;   // powered
        logic csc;   // connect change
        logic pesc;  // enable change
        logic pssc;  // suspend change
        logic ocic;  // over-current change
        logic prsc;  // reset change
    } port_stat_t;

    // stored fields of the hub-wide word
    typedef struct packed {
        logic b15;
        logic b1;
        logic b0;
    } hub_stat_t;

    function automatic logic [REG_W-1:0] pack_port(port_stat_t s);
        logic [REG_W-1:0] w;
        w     = '0;
        w[0]  = s.ccs;
        w[1]  = s.pes;
        w[2]  = s.pss;
        w[4]  = s.prs;
        w[8]  = s.pps;
        w[16] = s.csc;
        w[17] = s.pesc;
        w[18] = s.pssc;
        w[19] = s.ocic;
        w[20] = s.prsc;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_hub(hub_stat_t h);
        logic [REG_W-1:0] w;
        w     = '0;
        w[0]  = h.b0;
        w[1]  = h.b1;
        w[15] = h.b15;
        return w;
    endfunction

    // apply a set/clear command pair; both together keep the old value
    function automatic logic set_clr(logic cur, logic set_b, logic clr_b);
        if (set_b && !clr_b)
            return 1'b1;
        else if (clr_b && !set_b)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/rhp_port.sv
module rhp_port
    import rhp_pkg::*;
#(
    parameter int   RESET_TICKS = 10,
    parameter logic CONN_RST    = 1'b0,
    localparam int  CNT_W       = $clog2(RESET_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             conn_in,
    output logic [REG_W-1:0] stat_word,
    output logic             changed
);

    port_stat_t       st, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             restart, done;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[31:21], wr_data[15:10], wr_data[7:5]};

    always_comb begin
        nxt     = st;
        restart = 1'b0;
        if (wr_sel) begin
            nxt.pes = set_clr(st.pes, wr_data[1], wr_data[0]);
            nxt.pss = set_clr(st.pss, wr_data[2], wr_data[3]);
            nxt.pps = set_clr(st.pps, wr_data[8], wr_data[9]);
            if (wr_data[4]) begin
                nxt.prs = 1'b1;
                restart = 1'b1;
            end
            if (wr_data[16]) nxt.csc  = 1'b0;
            if (wr_data[17]) nxt.pesc = 1'b0;
            if (wr_data[18]) nxt.pssc = 1'b0;
            if (wr_data[19]) nxt.ocic = 1'b0;
            if (wr_data[20]) nxt.prsc = 1'b0;
        end
        // countdown completion overrides the host write
        done = !restart && tick && (cnt == CNT_W'(1));
        if (done) begin
            nxt.prs  = 1'b0;
            nxt.pes  = 1'b1;
            nxt.prsc = 1'b1;
        end
        // connect input overrides a host clear of the change bit
        if (conn_in != st.ccs) begin
            nxt.ccs = conn_in;
            nxt.csc = 1'b1;
        end
    end

    always_comb begin
        if (restart)
            cnt_nxt = CNT_W'(RESET_TICKS);
        else if (tick && cnt != '0)
            cnt_nxt = cnt - CNT_W'(1);
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            st.ccs <= CONN_RST;
            cnt    <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_nxt;
        end
    end

    assign stat_word = pack_port(st);
    assign changed   = pack_port(nxt) != pack_port(st);

    AST_RESET_SETS: assert property (@(posedge clk) disable iff (rst)
        wr_sel && wr_data[4] |=> st.prs); // R6

    AST_RESET_DONE: assert property (@(posedge clk) disable iff (rst)
        tick && cnt == CNT_W'(1) && !(wr_sel && wr_data[4])
        |=> !st.prs && st.pes && st.prsc); // R7

    AST_EN_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_sel && wr_data[1:0] == 2'b11 && !(tick && cnt == CNT_W'(1))
        |=> st.pes == $past(st.pes)); // R3

    AST_CONN_TRACK: assert property (@(posedge clk) disable iff (rst)
        conn_in != st.ccs |=> st.csc && st.ccs == $past(conn_in)); // R9

endmodule

// File: rtl/rhp_hub_status.sv
module rhp_hub_status
    import rhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [2:0]       clr_bits,
    input  logic [2:0]       set_bits,
    output logic [REG_W-1:0] stat_word
);

    hub_stat_t h, h_nxt;

    always_comb begin
        h_nxt = h;
        if (wr_sel) begin
            if (clr_bits[0]) h_nxt.b0  = 1'b0;
            if (clr_bits[1]) h_nxt.b1  = 1'b0;
            if (clr_bits[2]) h_nxt.b15 = 1'b0;
        end
        if (set_bits[0]) h_nxt.b0  = 1'b1;
        if (set_bits[1]) h_nxt.b1  = 1'b1;
        if (set_bits[2]) h_nxt.b15 = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            h <= '0;
        else
            h <= h_nxt;
    end

    assign stat_word = pack_hub(h);

    AST_HUB_CLEAR15: assert property (@(posedge clk) disable iff (rst)
        wr_sel && clr_bits[2] && !set_bits[2] |=> !h.b15); // R11

    AST_HUB_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_bits[0] |=> h.b0); // R11

endmodule

// File: rtl/rhp_rd_mux.sv
module rhp_rd_mux
    import rhp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [REG_W-1:0]                hub_word,
    input  logic [NUM_PORTS-1:0][REG_W-1:0] port_words,
    output logic [REG_W-1:0]                rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0)
            rd_data = hub_word;
        for (int i = 0; i < NUM_PORTS; i++)
            if (rd_addr == ADDR_W'(i + 1))
                rd_data = port_words[i];
    end

endmodule

// File: rtl/rhp_root_hub.sv
module rhp_root_hub
    import rhp_pkg::*;
#(
    parameter int  NUM_PORTS   = 4,
    parameter int  RESET_TICKS = 10,
    localparam int ADDR_W      = $clog2(NUM_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_tick,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_PORTS-1:0] conn_in,
    input  logic [2:0]           hub_set,
    output logic                 rhsc_req
);

    logic [NUM_PORTS-1:0][REG_W-1:0] port_words;
    logic [NUM_PORTS-1:0]            port_chg;
    logic [REG_W-1:0]                hub_word;
    logic                            rhsc_q;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        rhp_port #(
            .RESET_TICKS(RESET_TICKS),
            .CONN_RST   (i == 0)
        ) port_i (
            .clk      (clk),
            .rst      (rst),
            .tick     (frame_tick),
            .wr_sel   (wr_en && wr_addr == ADDR_W'(i + 1)),
            .wr_data  (wr_data),
            .conn_in  (conn_in[i]),
            .stat_word(port_words[i]),
            .changed  (port_chg[i])
        );
    end

    rhp_hub_status hub_i (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_en && wr_addr == '0),
        .clr_bits ({wr_data[31], wr_data[17], wr_data[16]}),
        .set_bits (hub_set),
        .stat_word(hub_word)
    );

    rhp_rd_mux #(
        .NUM_PORTS(NUM_PORTS),
        .ADDR_W   (ADDR_W)
    ) mux_i (
        .rd_addr   (rd_addr),
        .hub_word  (hub_word),
        .port_words(port_words),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rhsc_q <= 1'b0;
        else
            rhsc_q <= |port_chg;
    end

    assign rhsc_req = rhsc_q;

    AST_CHANGE_REQ: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_words) |-> rhsc_req); // R10

    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        $stable(port_words) |-> !rhsc_req); // R10

endmodule

// File: tb/rhp_root_hub_tb_top.sv
module rhp_root_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_tick;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic [3:0]  conn_in;
    logic [2:0]  hub_set;
    logic        rhsc_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rhp_root_hub dut_i (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .conn_in   (conn_in),
        .hub_set   (hub_set),
        .rhsc_req  (rhsc_req)
    );

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic        p;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd2, 32'h0000_0002, 32'h0000_0002, 1'b1},  // R3 set enable
        '{3'd2, 32'h0000_0003, 32'h0000_0002, 1'b0},  // R3 both
        '{3'd2, 32'h0000_0001, 32'h0000_0000, 1'b1},  // R3 clear
        '{3'd2, 32'h0000_0100, 32'h0000_0100, 1'b1},  // R5 set power
        '{3'd2, 32'h0000_0300, 32'h0000_0100, 1'b0},  // R5 both
        '{3'd2, 32'h0000_0200, 32'h0000_0000, 1'b1},  // R5 clear
        '{3'd2, 32'h0000_0004, 32'h0000_0004, 1'b1},  // R4 set suspend
        '{3'd2, 32'h0000_000C, 32'h0000_0004, 1'b0},  // R4 both
        '{3'd2, 32'h0000_0008, 32'h0000_0000, 1'b1},  // R4 clear
        '{3'd2, 32'h0000_0000, 32'h0000_0000, 1'b0},  // R8 zero write
        '{3'd5, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R1 unmapped
        '{3'd3, 32'h0000_0102, 32'h0000_0102, 1'b1},  // R3 R5 combined
        '{3'd2, 32'h001F_0000, 32'h0000_0000, 1'b0},  // R8 clears on zero
        '{3'd1, 32'h0000_0000, 32'h0000_0001, 1'b0}   // R8 port1 keeps connect
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_tick = 1'b0; wr_en = 1'b0; wr_addr = '0;
        wr_data = '0; rd_addr = '0; conn_in = 4'b0001; hub_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check_reg("R2 hub", 3'd0, 32'h0);
        check_reg("R2 port1", 3'd1, 32'h1);
        check_reg("R2 port2", 3'd2, 32'h0);
        check_reg("R2 port3", 3'd3, 32'h0);
        check_reg("R2 port4", 3'd4, 32'h0);
        check("R2 req", {31'b0, rhsc_req}, 32'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].a, VEC[v].d);
            check_reg($sformatf("vec%0d value", v), VEC[v].a, VEC[v].e);
            check($sformatf("R10 vec%0d req", v), {31'b0, rhsc_req}, {31'b0, VEC[v].p});
        end
        check_reg("R1 port4 after unmapped write", 3'd4, 32'h0);
        check_reg("R1 read addr7", 3'd7, 32'h0);

        // R6 / R7 reset sequence on port 4
        wr(3'd4, 32'h10);
        check_reg("R6 reset set", 3'd4, 32'h10);
        check("R10 reset req", {31'b0, rhsc_req}, 32'h1);
        ticks(9);
        check_reg("R6 still in reset", 3'd4, 32'h10);
        check("R10 no req while counting", {31'b0, rhsc_req}, 32'h0);
        ticks(1);
        check_reg("R7 done", 3'd4, 32'h0010_0002);
        check("R10 done req", {31'b0, rhsc_req}, 32'h1);
        @(negedge clk);
        check_reg("R12 read stable", 3'd4, 32'h0010_0002);
        check("R12 no req", {31'b0, rhsc_req}, 32'h0);

        // R6 reload
        wr(3'd4, 32'h0010_0001);
        check_reg("R8 clear prsc", 3'd4, 32'h0);
        wr(3'd4, 32'h10);
        ticks(5);
        wr(3'd4, 32'h10);
        check("R10 unchanged write no req", {31'b0, rhsc_req}, 32'h0);
        ticks(9);
        check_reg("R6 reload holds", 3'd4, 32'h10);
        ticks(1);
        check_reg("R6 reload done", 3'd4, 32'h0010_0002);

        // R7 completion against same-cycle write on port 2
        wr(3'd2, 32'h10);
        ticks(9);
        @(negedge clk);
        frame_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h0010_0001;
        @(negedge clk);
        frame_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        check_reg("R7 completion wins", 3'd2, 32'h0010_0002);

        // R9 connect on port 2
        @(negedge clk);
        conn_in = 4'b0011;
        @(negedge clk);
        check_reg("R9 connect", 3'd2, 32'h0011_0003);
        check("R10 connect req", {31'b0, rhsc_req}, 32'h1);
        wr(3'd2, 32'h0001_0000);
        check_reg("R8 clear csc", 3'd2, 32'h0010_0003);
        @(negedge clk);
        conn_in = 4'b0001; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h0001_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check_reg("R9 set beats clear", 3'd2, 32'h0011_0002);

        // R11 hub register
        @(negedge clk);
        hub_set = 3'b111;
        @(negedge clk);
        hub_set = 3'b000;
        check_reg("R11 hub set", 3'd0, 32'h0000_8003);
        wr(3'd0, 32'h8000_0000);
        check_reg("R11 clear 15", 3'd0, 32'h0000_0003);
        check("R10 hub write no req", {31'b0, rhsc_req}, 32'h0);
        wr(3'd0, 32'h0002_0000);
        check_reg("R11 clear 1", 3'd0, 32'h0000_0001);
        wr(3'd0, 32'h0001_0000);
        check_reg("R11 clear 0", 3'd0, 32'h0000_0000);
        @(negedge clk);
        hub_set = 3'b001; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0001_0000;
        @(negedge clk);
        hub_set = 3'b000; wr_en = 1'b0; wr_data = '0;
        check_reg("R11 set beats clear", 3'd0, 32'h0000_0001);
        check_reg("R1 port1 untouched", 3'd1, 32'h0000_0001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule